// File: doc/BRIEF.md
# Register-Driven I2C Master Byte Engine

This block is a single-master I2C engine that software runs one byte at a time through three 8-bit registers: control, status and data. Each register sits in bits 31:24 of its 32-bit bus word. The other 24 bits read as zero and are ignored on writes. The register is chosen by a 2-bit word index: 0 is control, 1 is status and 2 is data.

Software takes the bus by setting the master bit in the control register. It hands the bus back by clearing that bit, and it can insert a repeated START without letting go of the bus.

- **Transmit mode:** a write to the data register shifts that byte out and samples the slave's acknowledge.
- **Receive mode:** a read of the data register returns the byte already held and starts receiving the next one. The first read after a change of direction is therefore a dummy read.

A sticky completion flag marks the end of each byte. A bus-busy flag follows START and STOP conditions seen on the wires, whoever caused them. The SCL rate is set by a divider input: each SCL bit lasts 4*(div+1) clock cycles. SCL and SDA are open-drain. The block only pulls a line low through its `*_pull` outputs and reads the wire level back on its `*_in` inputs.

Control bits:
- bit 7: enable
- bit 6: master (bus ownership)
- bit 5: direction (1 = transmit)
- bit 4: answer with no-acknowledge
- bit 2: repeated START

Status bits:
- bit 7: byte complete
- bit 5: bus busy
- bit 0: acknowledge level received from the slave

Top module: `i2c_byte_master`

## Requirements
- R1: A register read returns its 8-bit value in bits 31:24 with bits 23:0 at zero. A write takes only bits 31:24, and the control register reads back what was written. After reset, control and status read as 0.
- R2: When the master bit (control bit 6) goes from 0 to 1 with enable (bit 7) set, the block generates a START: SDA falls while SCL is high, then SCL is held low. Bus busy (status bit 5) then reads 1.
- R3: With the bus owned and direction = transmit (control bit 5 = 1), a write to the data register sends the byte MSB first over nine SCL pulses. Byte complete (status bit 7) is then set and SCL is held low.
- R4: After a transmitted byte, status bit 0 holds the SDA level the slave gave on the ninth pulse: 0 for ACK, 1 for NACK.
- R5: With the bus owned and direction = receive (control bit 5 = 0), a read of the data register returns the value it held before the read and starts reception of one byte. The first read after switching returns the last transmitted byte. The received byte is what later reads return.
- R6: On a received byte, the master drives SDA low on the ninth pulse (ACK) when control bit 4 is 0, and leaves it released (NACK) when bit 4 is 1.
- R7: Byte complete stays set until software writes the status register with bit 7 = 0. Writing bit 7 = 1 leaves it set.
- R8: Writing control bit 2 = 1 while the bus is owned issues a repeated START with no STOP before it. Bit 2 always reads back 0.
- R9: Clearing the master bit while the bus is owned generates a STOP (SDA rises while SCL is high), after which both lines are released and bus busy reads 0.
- R10: Bus busy is set by any START and cleared by any STOP seen on the lines, including ones made by another driver while the block is disabled.
- R11: While enable is 0, both lines are released and no transfer is in progress.
- R12: During byte transfers, SDA changes only while SCL is low, so no extra START or STOP appears on the bus.
- R13: During a byte, consecutive SCL rising edges are 4*(div+1) clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_rd | input | 1 | Register read strobe, one cycle (side effect on the data register) |
| bus_addr | input | 2 | Register index: 0 control, 1 status, 2 data |
| bus_wdata | input | 32 | Write word; only bits 31:24 are used |
| bus_rdata | output | 32 | Read word; register in bits 31:24 |
| scl_div | input | DIV_W | Quarter-bit divider: quarter = scl_div+1 cycles |
| scl_in | input | 1 | SCL wire level |
| sda_in | input | 1 | SDA wire level |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions assume the following about the inputs:
- `scl_div` is at least 2 and stays constant, so a quarter bit is longer than the input synchronizer.
- A slave changes SDA only while SCL is low.
- No other device holds SCL low, because the block does not sample SCL for clock stretching.

The bench keeps within these limits. It fixes the divider at 3 and models a slave that updates its SDA drive only on falling SCL edges, releasing it after the master's NACK and on STOP. It drives a foreign START and STOP itself only while the engine is disabled.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

    typedef enum logic [2:0] {
        OP_START,
        OP_RSTART,
        OP_STOP,
        OP_TX,
        OP_RX
    } eng_op_e;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_HOLD,
        ENG_RUN
    } eng_state_e;

    typedef struct packed {
        logic       en;
        logic       mst;
        logic       txd;
        logic       nak;
        logic       rsv3;
        logic       rsta;
        logic [1:0] rsv;
    } ctrl_t;

    typedef struct packed {
        logic       done;
        logic       rsv6;
        logic       busy;
        logic [3:0] rsv;
        logic       rxak;
    } stat_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    localparam int BUS_W     = 32;
    localparam int REG_W     = 8;
    localparam int LANE_LSB  = BUS_W - REG_W;
    localparam int BIT_CNT_W = 4;
    localparam logic [BIT_CNT_W-1:0] ACK_SLOT = BIT_CNT_W'(REG_W);

    function automatic logic [REG_W-1:0] lane_get(input logic [BUS_W-1:0] w);
        return w[BUS_W-1:LANE_LSB];
    endfunction

    function automatic logic [BUS_W-1:0] lane_put(input logic [REG_W-1:0] b);
        return {b, {LANE_LSB{1'b0}}};
    endfunction

endpackage

// File: rtl/i2c_quarter_tick.sv
module i2c_quarter_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q == div);

    always_ff @(posedge clk) begin
        if (srst || restart || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_line_monitor.sv
module i2c_line_monitor #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic busy
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   sda_prev;
    logic                   saw_start;
    logic                   saw_stop;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_raw;
                    sda_pipe <= sda_raw;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_raw};
                    sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_raw};
                end
            end
        end
    endgenerate

    assign scl_s     = scl_pipe[SYNC_STAGES-1];
    assign sda_s     = sda_pipe[SYNC_STAGES-1];
    assign saw_start = scl_s && sda_prev && !sda_s;
    assign saw_stop  = scl_s && !sda_prev && sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sda_prev <= 1'b1;
            busy     <= 1'b0;
        end else begin
            sda_prev <= sda_s;
            if (saw_start) begin
                busy <= 1'b1;
            end else if (saw_stop) begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
    import i2c_eng_pkg::*;
(
    input  logic             clk,
    input  logic             srst,
    input  logic             tick,
    input  logic             cmd_valid,
    input  eng_op_e          cmd_op,
    input  logic [REG_W-1:0] cmd_byte,
    input  logic             cmd_nak,
    input  logic             sda_s,
    output eng_state_e       state_o,
    output eng_op_e          op_o,
    output logic             done_o,
    output logic             ack_o,
    output logic [REG_W-1:0] rx_o,
    output logic             scl_pull,
    output logic             sda_pull
);
    eng_state_e             state_q;
    eng_op_e                op_q;
    logic [1:0]             qtr_q;
    logic [BIT_CNT_W-1:0]   bit_q;
    logic [REG_W-1:0]       sh_q;
    logic                   nak_q;
    logic                   bit_pull;
    logic                   last_bit;

    assign last_bit = (bit_q == ACK_SLOT);

    // pull level for the current bit slot: data bits for transmit, answer bit for receive
    always_comb begin
        if (op_q == OP_TX) begin
            bit_pull = last_bit ? 1'b0 : !sh_q[REG_W-1];
        end else begin
            bit_pull = last_bit ? !nak_q : 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            state_q  <= ENG_IDLE;
            op_q     <= OP_START;
            qtr_q    <= '0;
            bit_q    <= '0;
            sh_q     <= '0;
            nak_q    <= 1'b0;
            scl_pull <= 1'b0;
            sda_pull <= 1'b0;
            done_o   <= 1'b0;
            ack_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                ENG_IDLE: begin
                    if (cmd_valid && cmd_op == OP_START) begin
                        state_q <= ENG_RUN;
                        op_q    <= OP_START;
                        qtr_q   <= '0;
                    end
                end
                ENG_HOLD: begin
                    if (cmd_valid && cmd_op != OP_START) begin
                        state_q <= ENG_RUN;
                        op_q    <= cmd_op;
                        qtr_q   <= '0;
                        bit_q   <= '0;
                        sh_q    <= cmd_byte;
                        nak_q   <= cmd_nak;
                    end
                end
                ENG_RUN: begin
                    if (tick) begin
                        qtr_q <= qtr_q + 1'b1;
                        unique case (op_q)
                            OP_START: begin
                                if (qtr_q == 2'd0) begin
                                    sda_pull <= 1'b1;
                                end else begin
                                    scl_pull <= 1'b1;
                                    state_q  <= ENG_HOLD;
                                end
                            end
                            OP_RSTART: begin
                                unique case (qtr_q)
                                    2'd0: sda_pull <= 1'b0;
                                    2'd1: scl_pull <= 1'b0;
                                    2'd2: sda_pull <= 1'b1;
                                    default: begin
                                        scl_pull <= 1'b1;
                                        state_q  <= ENG_HOLD;
                                    end
                                endcase
                            end
                            OP_STOP: begin
                                unique case (qtr_q)
                                    2'd0: sda_pull <= 1'b1;
                                    2'd1: scl_pull <= 1'b0;
                                    default: begin
                                        sda_pull <= 1'b0;
                                        state_q  <= ENG_IDLE;
                                    end
                                endcase
                            end
                            default: begin
                                unique case (qtr_q)
                                    2'd0: sda_pull <= bit_pull;
                                    2'd1: scl_pull <= 1'b0;
                                    2'd2: begin
                                        if (op_q == OP_RX && !last_bit) begin
                                            sh_q <= {sh_q[REG_W-2:0], sda_s};
                                        end
                                        if (op_q == OP_TX && last_bit) begin
                                            ack_o <= sda_s;
                                        end
                                    end
                                    default: begin
                                        scl_pull <= 1'b1;
                                        if (op_q == OP_TX && !last_bit) begin
                                            sh_q <= {sh_q[REG_W-2:0], 1'b0};
                                        end
                                        if (last_bit) begin
                                            state_q <= ENG_HOLD;
                                            done_o  <= 1'b1;
                                        end else begin
                                            bit_q <= bit_q + 1'b1;
                                        end
                                    end
                                endcase
                            end
                        endcase
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    assign state_o = state_q;
    assign op_o    = op_q;
    assign rx_o    = sh_q;
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2c_eng_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [DIV_W-1:0] scl_div,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_pull,
    output logic             sda_pull
);
    ctrl_t            ctrl_q;
    ctrl_t            ctrl_new;
    stat_t            stat_view;
    logic [REG_W-1:0] data_q;
    logic             done_q;
    logic             rxak_q;
    logic             start_req;
    logic             stop_req;
    logic             rsta_req;
    logic             byte_req;
    logic             byte_tx;

    logic             wr_ctrl;
    logic             wr_stat;
    logic             wr_data;
    logic             rd_data;
    logic             owned;
    logic             done_clr;

    logic             eng_srst;
    logic             tick;
    logic             cmd_valid;
    eng_op_e          cmd_op;
    eng_state_e       eng_state;
    eng_op_e          eng_op;
    logic             eng_done;
    logic             eng_ack;
    logic [REG_W-1:0] eng_rx;
    logic             scl_s;
    logic             sda_s;
    logic             bus_busy;

    assign ctrl_new = ctrl_t'(lane_get(bus_wdata));
    assign wr_ctrl  = bus_wr && bus_addr == ADDR_CTRL;
    assign wr_stat  = bus_wr && bus_addr == ADDR_STAT;
    assign wr_data  = bus_wr && bus_addr == ADDR_DATA;
    assign rd_data  = bus_rd && bus_addr == ADDR_DATA;
    assign owned    = ctrl_q.en && ctrl_q.mst;
    assign done_clr = wr_stat && !ctrl_new.en;
    assign eng_srst = rst || !ctrl_q.en;

    // command issue: START from idle; repeated START, byte, STOP from hold in that order
    always_comb begin
        cmd_valid = 1'b0;
        cmd_op    = OP_START;
        if (eng_state == ENG_IDLE) begin
            if (start_req) begin
                cmd_valid = 1'b1;
            end
        end else if (eng_state == ENG_HOLD) begin
            if (rsta_req) begin
                cmd_valid = 1'b1;
                cmd_op    = OP_RSTART;
            end else if (byte_req) begin
                cmd_valid = 1'b1;
                cmd_op    = byte_tx ? OP_TX : OP_RX;
            end else if (stop_req) begin
                cmd_valid = 1'b1;
                cmd_op    = OP_STOP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            data_q    <= '0;
            done_q    <= 1'b0;
            rxak_q    <= 1'b0;
            start_req <= 1'b0;
            stop_req  <= 1'b0;
            rsta_req  <= 1'b0;
            byte_req  <= 1'b0;
            byte_tx   <= 1'b0;
        end else begin
            if (!ctrl_q.en) begin
                start_req <= 1'b0;
                stop_req  <= 1'b0;
                rsta_req  <= 1'b0;
                byte_req  <= 1'b0;
            end
            if (cmd_valid) begin
                unique case (cmd_op)
                    OP_START:  start_req <= 1'b0;
                    OP_RSTART: rsta_req  <= 1'b0;
                    OP_STOP:   stop_req  <= 1'b0;
                    default:   byte_req  <= 1'b0;
                endcase
            end
            if (wr_ctrl) begin
                ctrl_q      <= ctrl_new;
                ctrl_q.rsta <= 1'b0;
                if (ctrl_new.en && ctrl_new.mst && !ctrl_q.mst) begin
                    start_req <= 1'b1;
                end
                if (ctrl_q.mst && !ctrl_new.mst) begin
                    stop_req  <= 1'b1;
                    start_req <= 1'b0;
                end
                if (ctrl_new.rsta && ctrl_new.mst && owned) begin
                    rsta_req <= 1'b1;
                end
            end
            if (wr_data) begin
                data_q <= lane_get(bus_wdata);
                if (owned && ctrl_q.txd) begin
                    byte_req <= 1'b1;
                    byte_tx  <= 1'b1;
                end
            end
            if (rd_data && owned && !ctrl_q.txd) begin
                byte_req <= 1'b1;
                byte_tx  <= 1'b0;
            end
            if (done_clr) begin
                done_q <= 1'b0;
            end
            if (eng_done) begin
                done_q <= 1'b1;
                if (eng_op == OP_TX) begin
                    rxak_q <= eng_ack;
                end else begin
                    data_q <= eng_rx;
                end
            end
        end
    end

    always_comb begin
        stat_view      = '0;
        stat_view.done = done_q;
        stat_view.busy = bus_busy;
        stat_view.rxak = rxak_q;
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = lane_put(ctrl_q);
            ADDR_STAT: bus_rdata = lane_put(stat_view);
            ADDR_DATA: bus_rdata = lane_put(data_q);
            default:   bus_rdata = '0;
        endcase
    end

    i2c_quarter_tick #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .srst    (eng_srst),
        .restart (cmd_valid),
        .div     (scl_div),
        .tick    (tick)
    );

    i2c_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk     (clk),
        .rst     (rst),
        .scl_raw (scl_in),
        .sda_raw (sda_in),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .busy    (bus_busy)
    );

    i2c_bit_engine u_eng (
        .clk       (clk),
        .srst      (eng_srst),
        .tick      (tick),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_byte  (data_q),
        .cmd_nak   (ctrl_q.nak),
        .sda_s     (sda_s),
        .state_o   (eng_state),
        .op_o      (eng_op),
        .done_o    (eng_done),
        .ack_o     (eng_ack),
        .rx_o      (eng_rx),
        .scl_pull  (scl_pull),
        .sda_pull  (sda_pull)
    );

    logic unused_ok;
    assign unused_ok = scl_s;
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk
    import i2c_eng_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       scl_pull,
    input logic       sda_pull,
    input eng_state_e eng_state,
    input eng_op_e    eng_op,
    input logic       eng_done,
    input logic       done_flag,
    input logic       done_clr
);
    AST_OFF_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!en && $past(!en)) |-> (!scl_pull && !sda_pull)); // R11

    AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (eng_state == ENG_RUN && $past(eng_state == ENG_RUN) &&
         (eng_op == OP_TX || eng_op == OP_RX) && !$stable(sda_pull)) |-> scl_pull); // R12

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(done_flag) && !$past(done_clr)) |-> done_flag); // R7

    AST_HOLD_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
        eng_done |-> scl_pull); // R3

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (eng_state == ENG_IDLE) |-> (!scl_pull && !sda_pull)); // R9
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (ctrl_q.en),
    .scl_pull  (scl_pull),
    .sda_pull  (sda_pull),
    .eng_state (eng_state),
    .eng_op    (eng_op),
    .eng_done  (eng_done),
    .done_flag (done_q),
    .done_clr  (done_clr)
);

// File: tb/tb_i2c_byte_master.sv
module tb_i2c_byte_master;
    localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;
    localparam logic [7:0] C_EN = 8'h80, C_MST = 8'h40, C_TXD = 8'h20, C_NAK = 8'h10, C_RSTA = 8'h04;
    localparam int DIV = 3;
    // {slave ack, byte}: bit8 = 1 slave acknowledges
    localparam logic [8:0] VEC [5] = '{9'h1A5, 9'h13C, 9'h0F0, 9'h100, 9'h0FF};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic scl_pull, sda_pull;
    logic tb_sda_pull = 1'b0;
    logic slv_pull;
    logic scl_w, sda_w;

    int nchk = 0, nerr = 0;

    always #10 clk = ~clk;

    assign scl_w = ~scl_pull;
    assign sda_w = ~(sda_pull | tb_sda_pull | slv_pull);

    i2c_byte_master dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scl_div(16'(DIV)),
        .scl_in(scl_w), .sda_in(sda_w), .scl_pull(scl_pull), .sda_pull(sda_pull)
    );

    // slave model
    int idx = 9;
    logic active = 1'b0;
    logic slv_sends = 1'b0;
    logic slv_ack = 1'b1;
    logic [7:0] slv_data = 8'h00;
    logic [7:0] shift = 8'h00, got_byte = 8'h00;
    logic m_ack = 1'b0;
    int n_start = 0, n_stop = 0;
    realtime last_rise = 0, rise_gap = 0;

    always @(negedge sda_w) if (scl_w === 1'b1) begin n_start++; idx = 9; active = 1'b1; end
    always @(posedge sda_w) if (scl_w === 1'b1) begin n_stop++;  idx = 9; active = 1'b0; end
    always @(posedge scl_w) begin
        if (idx < 8) begin
            shift = {shift[6:0], sda_w};
            if (idx == 7) got_byte = shift;
        end else if (idx == 8) begin
            m_ack = sda_w;
            if (slv_sends && sda_w) active = 1'b0;
        end
        rise_gap = $realtime - last_rise;
        last_rise = $realtime;
    end
    always @(negedge scl_w) idx = (idx >= 8) ? 0 : idx + 1;
    always_comb begin
        slv_pull = 1'b0;
        if (active && idx <= 8) begin
            if (slv_sends) slv_pull = (idx < 8) && !slv_data[7 - idx];
            else           slv_pull = (idx == 8) && slv_ack;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = {d, 24'h5A5A5A};
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done(input string req);
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(A_STAT, v);
            if (v[31]) return;
        end
        check(req, 32'h0, 32'h8000_0000);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int s0, p0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        rd(A_CTRL, v); check("R1 reset ctrl", v, 32'h0);
        rd(A_STAT, v); check("R1 reset status", v, 32'h0);
        check("R11 lines released at reset", {30'h0, scl_w, sda_w}, 32'h3);

        // R10: foreign START / STOP while disabled
        tb_sda_pull = 1'b1; idle(10);
        rd(A_STAT, v); check("R10 busy after foreign START", v & 32'h2000_0000, 32'h2000_0000);
        tb_sda_pull = 1'b0; idle(10);
        rd(A_STAT, v); check("R10 busy cleared by foreign STOP", v & 32'h2000_0000, 32'h0);
        n_start = 0; n_stop = 0;

        wr(A_CTRL, C_EN | C_TXD);
        rd(A_CTRL, v); check("R1 ctrl readback", v, {C_EN | C_TXD, 24'h0});

        // R2: START
        wr(A_CTRL, C_EN | C_MST | C_TXD); idle(40);
        check("R2 START seen", n_start, 1);
        check("R2 SCL held low", {31'h0, scl_w}, 32'h0);
        rd(A_STAT, v); check("R2 busy set", v & 32'h2000_0000, 32'h2000_0000);

        // table of transmitted bytes
        foreach (VEC[k]) begin
            slv_sends = 1'b0; slv_ack = VEC[k][8];
            wr(A_DATA, VEC[k][7:0]);
            wait_done("R3 byte completes");
            check("R3 byte received by slave MSB first", got_byte, VEC[k][7:0]);
            check("R3 SCL held low after byte", {31'h0, scl_w}, 32'h0);
            rd(A_STAT, v); check("R4 ack status", v & 32'h0100_0000, {7'h0, !VEC[k][8], 24'h0});
            if (k == 0) begin
                check("R13 SCL bit period", 32'(int'(rise_gap)), 32'(4 * (DIV + 1) * 20));
                wr(A_STAT, 8'h80);
                rd(A_STAT, v); check("R7 done kept by writing 1", v & 32'h8000_0000, 32'h8000_0000);
            end
            wr(A_STAT, 8'h00);
            rd(A_STAT, v); check("R7 done cleared by writing 0", v & 32'h8000_0000, 32'h0);
        end
        check("R12 no extra START during bytes", n_start, 1);
        check("R12 no STOP during bytes", n_stop, 0);

        // R8: repeated START
        wr(A_CTRL, C_EN | C_MST | C_TXD | C_RSTA); idle(60);
        check("R8 repeated START seen", n_start, 2);
        check("R8 no STOP before repeated START", n_stop, 0);
        rd(A_CTRL, v); check("R8 bit reads 0", v, {C_EN | C_MST | C_TXD, 24'h0});

        slv_sends = 1'b0; slv_ack = 1'b1;
        wr(A_DATA, 8'hA1); wait_done("R3 address byte"); wr(A_STAT, 8'h00);

        // R5 / R6: receive
        wr(A_CTRL, C_EN | C_MST);
        slv_sends = 1'b1; slv_data = 8'h5C;
        rd(A_DATA, v); check("R5 dummy read returns last sent byte", v, 32'hA100_0000);
        wait_done("R5 first receive");
        check("R6 master ACK when bit clear", {31'h0, m_ack}, 32'h0);
        wr(A_STAT, 8'h00);
        slv_data = 8'h93;
        wr(A_CTRL, C_EN | C_MST | C_NAK);
        rd(A_DATA, v); check("R5 read returns first received byte", v, 32'h5C00_0000);
        wait_done("R5 second receive");
        check("R6 master NACK when bit set", {31'h0, m_ack}, 32'h1);
        wr(A_STAT, 8'h00);

        // R9: STOP
        p0 = n_stop;
        wr(A_CTRL, C_EN | C_TXD); idle(60);
        check("R9 STOP seen", n_stop, p0 + 1);
        check("R9 lines released", {30'h0, scl_w, sda_w}, 32'h3);
        rd(A_STAT, v); check("R9 busy cleared", v & 32'h2000_0000, 32'h0);
        rd(A_DATA, v); check("R5 last received byte", v, 32'h9300_0000);

        // R11: disable while owning the bus
        s0 = n_start;
        wr(A_CTRL, C_EN | C_MST | C_TXD); idle(40);
        check("R2 START again", n_start, s0 + 1);
        wr(A_CTRL, 8'h00); idle(5);
        check("R11 lines released when disabled", {30'h0, scl_w, sda_w}, 32'h3);
        wr(A_DATA, 8'h55); idle(200);
        check("R11 no transfer while disabled", {31'h0, scl_w}, 32'h1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule